// File: doc/BRIEF.md
# Link Attach Event Detector

This block watches a single-cycle attach strobe coming from a chip-to-chip high-speed link PHY and records it in a sticky status flag. The strobe is already synchronised to the block clock. The flag only records a strobe when all of the following are true: the link is configured for the inter-chip mode, the high-speed force setting is on, and detection is enabled. In any other configuration the same strobe is dropped. It is not remembered for later.

Software reads the flag through a small register port. The flag appears at a fixed bit of one status word. Software clears it by writing a one to that bit. A level interrupt follows the flag whenever the interrupt enable is set and the link is in inter-chip mode. The control bits come in as plain inputs from a neighbouring configuration register.

Top module: `hsic_attach_det`

## Requirements
- R1: After reset the flag is 0, `conn_irq_o` is 0 and `reg_rdata_o` reads all zeros at every address.
- R2: A strobe on `conn_pulse_i` sets the flag at the next clock edge when `hsic_mode_i`, `hs_force_i` and `det_en_i` are all 1. From then on the status word at address `STAT_ADDR` (default 0x04) reads with bit 16 set.
- R3: A strobe is ignored when any one of `hsic_mode_i`, `hs_force_i` or `det_en_i` is 0. An ignored strobe leaves the flag at 0.
- R4: Once set, the flag stays set across idle cycles and across changes of the control inputs until software clears it.
- R5: A write with bit 16 of `reg_wdata_i` equal to 1 at address `STAT_ADDR` clears the flag at the next edge. A write with that bit equal to 0, or a write to any other address, leaves the flag unchanged.
- R6: If an accepted strobe and a clearing write land in the same cycle, the flag ends up set.
- R7: `conn_irq_o` is a combinational level equal to flag AND `irq_en_i` AND `hsic_mode_i`. It stays high for as long as those three terms hold.
- R8: A strobe ignored while detection was gated off does not set the flag when detection is enabled later.
- R9: Every bit of the status word other than bit 16 reads 0, and any address other than `STAT_ADDR` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsic_mode_i | input | 1 | Link is in inter-chip PHY mode |
| hs_force_i | input | 1 | High-speed force setting |
| det_en_i | input | 1 | Attach detection enable |
| irq_en_i | input | 1 | Attach interrupt enable |
| conn_pulse_i | input | 1 | One-cycle attach strobe from the PHY |
| reg_addr_i | input | ADDR_W (8) | Register port address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | DATA_W (32) | Register write data |
| reg_rdata_o | output | DATA_W (32) | Register read data, combinational on address |
| conn_irq_o | output | 1 | Level interrupt |

## Verification
The only internal state is the flag, and it shows at the ports on the same cycle. A wrong flag value appears on bit 16 of the status word, and on the interrupt when it is enabled, in the cycle right after the edge that corrupted it. The bench drives mixed gating, clear and strobe patterns. Each cycle it compares both outputs against a behavioural model. A latch on a gated strobe, a lost sticky value or a wrong set-versus-clear priority is therefore caught within one clock.

// File: rtl/hsic_attach_pkg.sv
package hsic_attach_pkg;

   typedef struct packed {
      logic mode;
      logic hs_force;
      logic det_en;
      logic irq_en;
   } attach_ctrl_t;

   function automatic logic detect_armed(input attach_ctrl_t c);
      return c.mode & c.hs_force & c.det_en;
   endfunction

endpackage

// File: rtl/hsic_attach_qual.sv
module hsic_attach_qual
   import hsic_attach_pkg::*;
(
   input  attach_ctrl_t ctrl_i,
   input  logic         pulse_i,
   output logic         set_o
);
   logic armed;

   assign armed = detect_armed(ctrl_i);
   assign set_o = armed & pulse_i;
endmodule

// File: rtl/hsic_attach_flag.sv
module hsic_attach_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o);
   p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !flag_o);
   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o);
endmodule

// File: rtl/hsic_attach_regs.sv
module hsic_attach_regs #(
   parameter int unsigned              ADDR_W    = 8,
   parameter int unsigned              DATA_W    = 32,
   parameter int unsigned              STAT_BIT  = 16,
   parameter logic [ADDR_W-1:0]        STAT_ADDR = 'h04
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              flag_i,
   output logic              clr_o,
   output logic [DATA_W-1:0] rdata_o
);
   localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'(1) << STAT_BIT;

   generate
      if (STAT_BIT >= DATA_W) begin : g_bad_bit
         $error("STAT_BIT must lie inside the data word");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic hit;
   logic unused_wdata;

   assign hit          = (addr_i == STAT_ADDR);
   assign clr_o        = hit & wr_i & wdata_i[STAT_BIT];
   assign rdata_o      = hit ? (flag_i ? STAT_MASK : '0) : '0;
   assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/hsic_attach_det.sv
module hsic_attach_det
   import hsic_attach_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 8,
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       STAT_BIT  = 16,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h04,
   parameter bit                IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsic_mode_i,
   input  logic              hs_force_i,
   input  logic              det_en_i,
   input  logic              irq_en_i,
   input  logic              conn_pulse_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              conn_irq_o
);
   attach_ctrl_t ctrl;
   logic         set_w;
   logic         clr_w;
   logic         flag_w;
   logic         irq_raw;

   assign ctrl = '{mode: hsic_mode_i, hs_force: hs_force_i,
                   det_en: det_en_i, irq_en: irq_en_i};

   hsic_attach_qual u_qual (
      .ctrl_i  (ctrl),
      .pulse_i (conn_pulse_i),
      .set_o   (set_w)
   );

   hsic_attach_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_w),
      .clr_i  (clr_w),
      .flag_o (flag_w)
   );

   hsic_attach_regs #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STAT_BIT  (STAT_BIT),
      .STAT_ADDR (STAT_ADDR)
   ) u_regs (
      .addr_i  (reg_addr_i),
      .wr_i    (reg_wr_i),
      .wdata_i (reg_wdata_i),
      .flag_i  (flag_w),
      .clr_o   (clr_w),
      .rdata_o (reg_rdata_o)
   );

   assign irq_raw = flag_w & ctrl.irq_en & ctrl.mode;

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign conn_irq_o = irq_q;
      end else begin : g_irq_comb
         assign conn_irq_o = irq_raw;
         p_irq_needs_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !hsic_mode_i |-> !conn_irq_o);
         p_irq_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !irq_en_i |-> !conn_irq_o);
      end
   endgenerate

   p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_pulse_i && hsic_mode_i && hs_force_i && det_en_i)
      |=> (reg_addr_i != STAT_ADDR || reg_rdata_o[STAT_BIT]));
   p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_w && !(conn_pulse_i && hsic_mode_i && hs_force_i && det_en_i))
      |=> !flag_w);
   p_other_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i != STAT_ADDR) |-> (reg_rdata_o == '0));
   p_single_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(reg_rdata_o) <= 1);
endmodule

// File: tb/hsic_attach_det_tb.sv
module hsic_attach_det_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 8;
   localparam int DW = 32;
   localparam int SB = 16;
   localparam logic [AW-1:0] SA = 8'h04;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode = 0, force_hs = 0, det = 0, ien = 0, pulse = 0, wr = 0;
   logic [AW-1:0] addr = SA;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic irq;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  m_st  = 0;
   bit  done  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hsic_attach_det u_dut (
      .clk(clk), .rst_n(rst_n), .hsic_mode_i(mode), .hs_force_i(force_hs),
      .det_en_i(det), .irq_en_i(ien), .conn_pulse_i(pulse),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .conn_irq_o(irq)
   );

   task automatic compare(input string tag);
      logic [DW-1:0] exp_rd;
      logic exp_irq;
      exp_rd  = (addr == SA && m_st) ? (DW'(1) << SB) : '0;
      exp_irq = m_st & ien & mode;
      n_chk++;
      if (rdata !== exp_rd) begin
         n_bad++;
         $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, exp_rd);
      end
      n_chk++;
      if (irq !== exp_irq) begin
         n_bad++;
         $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp_irq);
      end
   endtask

   // inputs set after a falling edge; check, then advance one cycle
   task automatic tick(input string tag);
      bit set, clr;
      #1;
      compare(tag);
      set = pulse & mode & force_hs & det;
      clr = wr & (addr == SA) & wdata[SB];
      @(posedge clk);
      if (set)      m_st = 1;
      else if (clr) m_st = 0;
      @(negedge clk);
   endtask

   task automatic idle();
      pulse = 0; wr = 0; wdata = '0; addr = SA;
   endtask

   task automatic gates(input bit m, input bit f, input bit d);
      mode = m; force_hs = f; det = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state at several addresses
      repeat (2) @(negedge clk);
      addr = SA; #1; compare("R1");
      addr = 8'h00; #1; compare("R1");
      @(negedge clk); rst_n = 1; addr = SA;
      tick("R1");

      // R3: each single missing gate drops the strobe
      gates(0,1,1); pulse = 1; tick("R3"); idle(); tick("R3");
      gates(1,0,1); pulse = 1; tick("R3"); idle(); tick("R3");
      gates(1,1,0); pulse = 1; tick("R3"); idle(); tick("R3");
      // R8: enabling later does not recall dropped strobes
      gates(1,1,1); tick("R8"); tick("R8"); tick("R8");

      // R2: accepted strobe
      pulse = 1; tick("R2"); idle(); tick("R2");
      // R4: sticky across control changes
      gates(0,0,0); tick("R4"); tick("R4");
      gates(1,1,1);
      // R7: interrupt level
      ien = 1; tick("R7"); tick("R7");
      mode = 0; tick("R7");
      mode = 1; ien = 0; tick("R7");
      ien = 1; tick("R7");
      // R9: other address reads zero
      addr = 8'h08; tick("R9"); addr = SA;
      // R5: non-clearing writes
      wr = 1; wdata = ~(DW'(1) << SB); tick("R5");
      addr = 8'h08; wdata = DW'(1) << SB; tick("R5");
      idle(); tick("R5");
      // R5: clearing write
      wr = 1; wdata = DW'(1) << SB; tick("R5");
      idle(); tick("R5"); tick("R7");

      // R6: set wins over same-cycle clear
      pulse = 1; tick("R6"); idle(); tick("R6");
      pulse = 1; wr = 1; wdata = '1; tick("R6");
      idle(); tick("R6");
      // gated strobe with clear: clear applies
      gates(1,0,1); pulse = 1; wr = 1; wdata = DW'(1) << SB; tick("R3");
      idle(); tick("R3");

      // mixed random traffic against the model
      for (int i = 0; i < 400; i++) begin
         mode     = $urandom_range(0,3) != 0;
         force_hs = $urandom_range(0,3) != 0;
         det      = $urandom_range(0,3) != 0;
         ien      = $urandom_range(0,1);
         pulse    = $urandom_range(0,3) == 0;
         wr       = $urandom_range(0,3) == 0;
         wdata    = $urandom_range(0,1) ? (DW'(1) << SB) : DW'($urandom);
         addr     = $urandom_range(0,3) == 0 ? 8'h10 : SA;
         tick("R2");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule